// File: doc/BRIEF.md
# Real-Time Counter with Compare Wake-Up

This block keeps time from a slow 32.768 kHz reference that reaches the register clock domain as a one-cycle enable pulse. A 15-bit sub-second counter advances on every pulse. When it wraps, it carries into a 24-bit seconds counter, which spans roughly 194 days. A compare unit watches both counters. It raises a sticky wake-up flag when the low byte of the seconds count and the whole sub-second count equal two programmed values. This gives a wake-up delay that can be set anywhere from a single tick (about 30.5 µs) to 256 seconds.

The counters have no reset input. They survive every system reset and are zeroed only by a deliberate software command. Software reaches the block through a simple single-cycle write strobe with an address and data. Reads return data combinationally for the presented address. Software can preload either counter, program the two compare values, set the interrupt enable, and clear the flag.

Top module: `rtc_wake_timer`

## Requirements
- R1: On each cycle with `tick` high and no counter write, the sub-second count (read at address 0 or 2, bits 14:0) increments by one, and wraps from 32767 to 0.
- R2: When the sub-second count wraps, the seconds count (address 1, bits 23:0) increments by one, and wraps from 0xFFFFFF to 0.
- R3: With `tick` low and no counter write, both counters hold their values.
- R4: A write to address 0 with data bit 0 equal to 0 zeroes both counters at that clock edge. A write to address 0 with bit 0 equal to 1 leaves them unchanged.
- R5: `rst_n` low leaves both counters unchanged. It returns the two compare values, the enable and the flag to 0.
- R6: A write to address 1 loads the seconds count from data bits 23:0. A write to address 2 loads the sub-second count from data bits 14:0. The load takes precedence over a `tick` in the same cycle, and that tick is lost.
- R7: The flag sets at the edge that ends a cycle in which the enable is 1 and the counters match. A match means seconds bits 7:0 equal the seconds compare value (address 3, bits 7:0) and the sub-second count equals the sub-second compare value (address 4, bits 14:0). `irq` equals the flag.
- R8: In a cycle that writes address 3 or 4, the flag cannot become set.
- R9: While the enable (address 5, bit 0) is 0, the flag never becomes set.
- R10: The flag stays set until a write to address 5 with data bit 1 equal to 1. That write clears it at that edge, even if a match exists in the same cycle. The same write loads the enable from bit 0.
- R11: Reads return the sub-second count at addresses 0 and 2, the seconds count at 1, the compare values at 3 and 4, and {flag, enable} in bits 1:0 at address 5. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset; does not touch the counters |
| tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky wake-up interrupt flag |

## Verification
The hardest situations to reach from the ports are the cycles where a match already holds and another event competes in the same edge. These include a compare-register write, a flag clear, or an enable change. Stimulus reaches them by freezing the counters at a matching value with `tick` held low. It then issues back-to-back writes and samples `irq` before and after the competing write. Wrap and carry corners are reached by preloading the counters one tick before their limits, instead of waiting out 32768 ticks. A sweep over small sub-second compare values counts the ticks up to the exact edge of the match.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
   // Register addresses; software-visible map
   localparam logic [2:0] ADR_CLEAR   = 3'd0;  // write bit0=0 clears counters, read sub-second
   localparam logic [2:0] ADR_SECONDS = 3'd1;
   localparam logic [2:0] ADR_SUBSEC  = 3'd2;
   localparam logic [2:0] ADR_CMP_SEC = 3'd3;
   localparam logic [2:0] ADR_CMP_SUB = 3'd4;
   localparam logic [2:0] ADR_CONTROL = 3'd5;

   localparam int unsigned CTL_ENABLE_BIT = 0;
   localparam int unsigned CTL_FLAG_BIT   = 1;
endpackage

// File: rtl/rtc_wake_counter.sv
module rtc_wake_counter #(
   parameter int unsigned SUB_W = 15,
   parameter int unsigned SEC_W = 24
) (
   input  logic             clk,
   input  logic             tick,
   input  logic             zero_all,
   input  logic             load_sub,
   input  logic             load_sec,
   input  logic [SUB_W-1:0] load_sub_val,
   input  logic [SEC_W-1:0] load_sec_val,
   output logic [SUB_W-1:0] sub_q,
   output logic [SEC_W-1:0] sec_q
);
   localparam logic [SUB_W-1:0] SUB_LAST = '1;
   localparam logic [SUB_W-1:0] SUB_ONE  = SUB_W'(1);
   localparam logic [SEC_W-1:0] SEC_ONE  = SEC_W'(1);

   // No reset input by intent: only the software clear zeroes the chain.
   always_ff @(posedge clk) begin
      if (zero_all) begin
         sub_q <= '0;
         sec_q <= '0;
      end else if (load_sub || load_sec) begin
         if (load_sub) sub_q <= load_sub_val;
         if (load_sec) sec_q <= load_sec_val;
      end else if (tick) begin
         if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            sec_q <= sec_q + SEC_ONE;
         end else begin
            sub_q <= sub_q + SUB_ONE;
         end
      end
   end
endmodule

// File: rtl/rtc_wake_match.sv
module rtc_wake_match #(
   parameter int unsigned SUB_W     = 15,
   parameter int unsigned SEC_W     = 24,
   parameter int unsigned CMP_SEC_W = 8
) (
   input  logic [SUB_W-1:0]     sub_q,
   input  logic [SEC_W-1:0]     sec_q,
   input  logic [SUB_W-1:0]     cmp_sub,
   input  logic [CMP_SEC_W-1:0] cmp_sec,
   output logic                 hit
);
   logic sec_eq;

   generate
      if (CMP_SEC_W == SEC_W) begin : g_full_sec
         assign sec_eq = (sec_q == cmp_sec);
      end else begin : g_low_sec
         logic unused_sec_hi;
         assign unused_sec_hi = ^sec_q[SEC_W-1:CMP_SEC_W];
         assign sec_eq = (sec_q[CMP_SEC_W-1:0] == cmp_sec);
      end
   endgenerate

   assign hit = sec_eq && (sub_q == cmp_sub);
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer
   import rtc_wake_pkg::*;
#(
   parameter int unsigned SUB_W     = 15,
   parameter int unsigned SEC_W     = 24,
   parameter int unsigned CMP_SEC_W = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   // Elaboration-time parameter checks
   generate
      if (CMP_SEC_W > SEC_W) begin : g_bad_cmp
         $error("seconds compare width exceeds seconds counter width");
      end
      if (SEC_W > DATA_W || SUB_W > DATA_W) begin : g_bad_data
         $error("counter wider than data bus");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address bus too narrow for register map");
      end
      if (DATA_W < 2) begin : g_bad_ctl
         $error("data bus too narrow for control bits");
      end
   endgenerate

   logic [SUB_W-1:0]     sub_q;
   logic [SEC_W-1:0]     sec_q;
   logic [SUB_W-1:0]     cmp_sub_q;
   logic [CMP_SEC_W-1:0] cmp_sec_q;
   logic                 en_q;
   logic                 flag_q;
   logic                 hit;

   logic wr_clear, wr_sec, wr_sub, wr_cmp_sec, wr_cmp_sub, wr_ctl, cmp_busy;

   assign wr_clear   = bus_wr && (bus_addr == ADDR_W'(ADR_CLEAR)) && !bus_wdata[0];
   assign wr_sec     = bus_wr && (bus_addr == ADDR_W'(ADR_SECONDS));
   assign wr_sub     = bus_wr && (bus_addr == ADDR_W'(ADR_SUBSEC));
   assign wr_cmp_sec = bus_wr && (bus_addr == ADDR_W'(ADR_CMP_SEC));
   assign wr_cmp_sub = bus_wr && (bus_addr == ADDR_W'(ADR_CMP_SUB));
   assign wr_ctl     = bus_wr && (bus_addr == ADDR_W'(ADR_CONTROL));
   assign cmp_busy   = wr_cmp_sec || wr_cmp_sub;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   rtc_wake_counter #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_count (
      .clk          (clk),
      .tick         (tick),
      .zero_all     (wr_clear),
      .load_sub     (wr_sub),
      .load_sec     (wr_sec),
      .load_sub_val (bus_wdata[SUB_W-1:0]),
      .load_sec_val (bus_wdata[SEC_W-1:0]),
      .sub_q        (sub_q),
      .sec_q        (sec_q)
   );

   rtc_wake_match #(.SUB_W(SUB_W), .SEC_W(SEC_W), .CMP_SEC_W(CMP_SEC_W)) u_match (
      .sub_q   (sub_q),
      .sec_q   (sec_q),
      .cmp_sub (cmp_sub_q),
      .cmp_sec (cmp_sec_q),
      .hit     (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_sub_q <= '0;
         cmp_sec_q <= '0;
         en_q      <= 1'b0;
      end else begin
         if (wr_cmp_sub) cmp_sub_q <= bus_wdata[SUB_W-1:0];
         if (wr_cmp_sec) cmp_sec_q <= bus_wdata[CMP_SEC_W-1:0];
         if (wr_ctl)     en_q      <= bus_wdata[CTL_ENABLE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (wr_ctl && bus_wdata[CTL_FLAG_BIT]) begin
         flag_q <= 1'b0;
      end else if (hit && en_q && !cmp_busy) begin
         flag_q <= 1'b1;
      end
   end

   assign irq = flag_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(ADR_CLEAR),
         ADDR_W'(ADR_SUBSEC):  bus_rdata[SUB_W-1:0]     = sub_q;
         ADDR_W'(ADR_SECONDS): bus_rdata[SEC_W-1:0]     = sec_q;
         ADDR_W'(ADR_CMP_SEC): bus_rdata[CMP_SEC_W-1:0] = cmp_sec_q;
         ADDR_W'(ADR_CMP_SUB): bus_rdata[SUB_W-1:0]     = cmp_sub_q;
         ADDR_W'(ADR_CONTROL): begin
            bus_rdata[CTL_ENABLE_BIT] = en_q;
            bus_rdata[CTL_FLAG_BIT]   = flag_q;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_wake_timer_chk.sv
module rtc_wake_timer_chk #(
   parameter int unsigned SUB_W  = 15,
   parameter int unsigned SEC_W  = 24,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input logic              en_q,
   input logic [SUB_W-1:0]  sub_q,
   input logic [SEC_W-1:0]  sec_q
);
   localparam logic [SUB_W-1:0] SUB_LAST = '1;
   localparam logic [SUB_W-1:0] SUB_ONE  = SUB_W'(1);
   localparam logic [SEC_W-1:0] SEC_ONE  = SEC_W'(1);

   logic cmp_wr, clr_wr, flag_clr;
   assign cmp_wr   = bus_wr && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(4));
   assign clr_wr   = bus_wr && (bus_addr == ADDR_W'(0)) && !bus_wdata[0];
   assign flag_clr = bus_wr && (bus_addr == ADDR_W'(5)) && bus_wdata[1];

   AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !bus_wr) |=> (sub_q == (($past(sub_q) == SUB_LAST) ? '0 : $past(sub_q) + SUB_ONE))); // R1
   AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !bus_wr && sub_q == SUB_LAST) |=> (sec_q == $past(sec_q) + SEC_ONE)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> ($stable(sub_q) && $stable(sec_q))); // R3
   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (sub_q == '0 && sec_q == '0)); // R4
   AST_CMP_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !$rose(irq)); // R8
   AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !$rose(irq)); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !flag_clr) |=> irq); // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !irq); // R10
endmodule

bind rtc_wake_timer rtc_wake_timer_chk #(
   .SUB_W(SUB_W), .SEC_W(SEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .en_q      (en_q),
   .sub_q     (sub_q),
   .sec_q     (sec_q)
);

// File: tb/rtc_wake_timer_bench.sv
module rtc_wake_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick;
   logic        bus_wr;
   logic [2:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] rv;
   logic        irq_s;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_wake_timer u_rtc_wake_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [2:0] a);
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0; bus_addr = a;
      #1;
      rv = bus_rdata;
      irq_s = irq;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_wr = 1'b0; tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(3'd5); check("R5 control after reset", rv, 32'h0);
      check("R5 irq after reset", {31'h0, irq_s}, 32'h0);
      rd(3'd3); check("R5 seconds compare after reset", rv, 32'h0);

      wr(3'd0, 32'h0);
      rd(3'd0); check("R4 clear sub-second", rv, 32'h0);
      rd(3'd1); check("R4 clear seconds", rv, 32'h0);

      ticks(5);
      rd(3'd0); check("R1 five ticks", rv, 32'd5);
      rd(3'd2); check("R11 sub-second alias read", rv, 32'd5);
      repeat (4) rd(3'd0);
      check("R3 hold without tick", rv, 32'd5);
      wr(3'd0, 32'h1);
      rd(3'd0); check("R4 write with bit0 set ignored", rv, 32'd5);

      wr(3'd2, 32'd32767); wr(3'd1, 32'd5); ticks(1);
      rd(3'd0); check("R1 sub-second wrap", rv, 32'd0);
      rd(3'd1); check("R2 carry into seconds", rv, 32'd6);

      wr(3'd1, 32'h00FF_FFFF); wr(3'd2, 32'd32767); ticks(1);
      rd(3'd1); check("R2 seconds wrap", rv, 32'd0);

      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'd100; tick = 1'b1;
      rd(3'd0); check("R6 load beats tick", rv, 32'd100);
      rd(3'd1); check("R6 seconds untouched by lost tick", rv, 32'd0);

      wr(3'd3, 32'd9); wr(3'd5, 32'd1);
      @(negedge clk); bus_wr = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(3'd0); check("R5 counters survive reset", rv, 32'd100);
      rd(3'd3); check("R5 compare reset", rv, 32'd0);
      rd(3'd5); check("R5 enable reset", rv, 32'd0);

      wr(3'd3, 32'd6); wr(3'd4, 32'd3); wr(3'd1, 32'd6); wr(3'd2, 32'd0); wr(3'd5, 32'd1);
      ticks(2); rd(3'd5);
      check("R7 no flag before match", {31'h0, irq_s}, 32'h0);
      ticks(1); rd(3'd5);
      check("R7 flag at match", rv, 32'h3);
      ticks(3); rd(3'd5);
      check("R10 flag sticky after match passes", {31'h0, irq_s}, 32'h1);
      wr(3'd5, 32'h3); rd(3'd5);
      check("R10 flag cleared", rv, 32'h1);

      wr(3'd2, 32'd3); wr(3'd5, 32'h3); rd(3'd5);
      check("R10 clear wins over match", {31'h0, irq_s}, 32'h0);
      rd(3'd5);
      check("R10 match sets flag after clear", {31'h0, irq_s}, 32'h1);

      wr(3'd5, 32'h2); rd(3'd5); rd(3'd5);
      check("R9 disabled match no flag", {31'h0, irq_s}, 32'h0);

      wr(3'd1, 32'h106); wr(3'd5, 32'h1); rd(3'd5); rd(3'd5);
      check("R7 only low seconds byte compared", {31'h0, irq_s}, 32'h1);
      wr(3'd5, 32'h2); wr(3'd1, 32'h107); wr(3'd5, 32'h1); rd(3'd5); rd(3'd5);
      check("R7 low byte mismatch", {31'h0, irq_s}, 32'h0);

      wr(3'd5, 32'h2); wr(3'd1, 32'd6);
      wr(3'd5, 32'h1); wr(3'd4, 32'd3); wr(3'd3, 32'd6);
      rd(3'd5);
      check("R8 compare writes block flag", {31'h0, irq_s}, 32'h0);
      rd(3'd5);
      check("R8 flag after compare writes end", {31'h0, irq_s}, 32'h1);

      for (int k = 1; k <= 12; k++) begin
         wr(3'd5, 32'h2); wr(3'd0, 32'h0); wr(3'd3, 32'd0); wr(3'd4, k); wr(3'd5, 32'h1);
         ticks(k - 1); rd(3'd4);
         check("R11 sub-second compare readback", rv, k);
         rd(3'd5);
         check("R7 sweep one tick early", {31'h0, irq_s}, 32'h0);
         ticks(1); rd(3'd5);
         check("R7 sweep at match", {31'h0, irq_s}, 32'h1);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule